// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block is the command interpreter of a byte-wide parallel NOR flash, written as a synchronous model. On each clock edge where the write strobe is high, it looks at an 18-bit address and an 8-bit data byte. It follows the multi-cycle unlock-and-command sequences and turns each finished sequence into a one-cycle request on its own output. The requests are byte program, full-chip erase, boot-region lockout, and entry to or exit from identification mode. The block does not hold the array, time the program pulses or model any analog protection. Those belong to the logic that consumes these requests.

The block holds two flags. The identification-mode flag is cleared by the ordinary reset, which stands for loss of power. The boot-region lockout flag models a nonvolatile bit: once set it stays set, and only the power-on initialization input clears it. When the lockout flag is set, the block refuses program requests inside the boot region, and every erase request tells the array to keep the boot region. While identification mode is active, a separate read port returns the manufacturer code, the device code and the lockout status.

Top module: `nor_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, all request outputs and `id_mode` are 0 and the decoder returns to idle. While `por_n` is low, `boot_locked` is 0.
- R2: A byte program is the sequence AA at 5555h, then 55 at 2AAAh, then A0 at 5555h, then one write to any address with any data. `prog_req` is high for exactly one cycle, in the cycle after that fourth write, with `prog_addr` and `prog_data` equal to the fourth write's address and data.
- R3: A full-chip erase is the sequence AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 10@5555h. `erase_req` is high for one cycle after the sixth write, and `erase_keep_boot` equals `boot_locked` in that cycle.
- R4: The same six-cycle sequence ending in 40@5555h sets `boot_locked` one cycle after `lock_req` pulses. `lock_req` pulses only if the flag was clear. The flag survives `rst_n` and is cleared only by `por_n`.
- R5: While `boot_locked` is 1, a program whose target lies in the boot region (addresses 00000h to 01FFFh) produces no `prog_req`. Targets at 02000h and above are still issued.
- R6: The sequence AA@5555h, 55@2AAAh, 90@5555h sets `id_mode` one cycle after the third write. `id_enter_req` pulses in that cycle only if the mode was off.
- R7: Identification mode is left by AA@5555h, 55@2AAAh, F0@5555h, or by a single F0 to any address while the decoder is idle. `id_exit_req` pulses only if the mode was on.
- R8: `id_rd_data` is a combinational function of `rd_addr`. With `id_mode` set, address 0 returns 1Fh, address 1 returns 0Bh, address 2 returns bit 0 = `boot_locked` with the other bits 0, and any other address returns 00h. With `id_mode` clear, every address returns 00h.
- R9: Only address bits 14..0 are compared against 5555h and 2AAAh. Bits 17..15 of an unlock or command write are ignored.
- R10: A write that does not match the expected next step returns the decoder to idle. If that write is AA@5555h, it begins a new sequence instead.
- R11: At most one request output is high in any cycle, and every request follows a cycle in which `wr_en` was high.
- R12: A low pulse on `rst_n` clears `id_mode` and leaves `boot_locked` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the sequence state and identification mode |
| por_n | input | 1 | Active-low power-on initialization; clears the lockout flag |
| wr_en | input | 1 | Write cycle strobe, sampled on the rising clock edge |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 18 | Address of an identification read |
| prog_req | output | 1 | One-cycle byte program request |
| prog_addr | output | 18 | Target address of the program request |
| prog_data | output | 8 | Data of the program request |
| erase_req | output | 1 | One-cycle chip erase request |
| erase_keep_boot | output | 1 | High with `erase_req` when the boot region must be kept |
| lock_req | output | 1 | One-cycle pulse when lockout is first enabled |
| id_enter_req | output | 1 | One-cycle pulse when identification mode turns on |
| id_exit_req | output | 1 | One-cycle pulse when identification mode turns off |
| id_mode | output | 1 | Identification mode flag |
| boot_locked | output | 1 | Boot-region lockout flag |
| id_rd_data | output | 8 | Identification read data |

## Verification
The assertions assume that `wr_en` stays low while `rst_n` is low. They also assume that `por_n` is never released in the same cycle that a lockout sequence completes, so the flag has only one writer at a time. The bench drives every input on the falling clock edge, holds `wr_en` low through both reset inputs, and separates every lockout and erase sequence from any change of `por_n` by idle cycles. Identification reads are applied only while no write is in flight, so the combinational read path settles before it is sampled.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE  = 3'd0,
      SEQ_KEY1  = 3'd1,
      SEQ_KEY2  = 3'd2,
      SEQ_PGM   = 3'd3,
      SEQ_EXT1  = 3'd4,
      SEQ_EXT2  = 3'd5,
      SEQ_EXT3  = 3'd6
   } seq_state_t;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam logic [7:0] OP_PROGRAM = 8'hA0;
   localparam logic [7:0] OP_EXTEND  = 8'h80;
   localparam logic [7:0] OP_ID_ON   = 8'h90;
   localparam logic [7:0] OP_ID_OFF  = 8'hF0;
   localparam logic [7:0] OP_ERASE   = 8'h10;
   localparam logic [7:0] OP_LOCK    = 8'h40;

endpackage

// File: rtl/nor_lock_reg.sv
module nor_lock_reg (
   input  logic clk,
   input  logic por_n,
   input  logic set_i,
   output logic locked_o
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) locked_o <= 1'b0;
      else if (set_i) locked_o <= 1'b1;
   end

   // R4: once set, the flag holds until power-on initialization
   a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
      locked_o |=> locked_o);

   // R4: the flag rises only after a set request
   a_r4_lock_rise: assert property (@(posedge clk) disable iff (!por_n)
      $rose(locked_o) |-> $past(set_i));

endmodule

// File: rtl/nor_id_port.sv
module nor_id_port #(
   parameter int         ADDR_W = 18,
   parameter int         DATA_W = 8,
   parameter logic [7:0] MFR_CODE = 8'h1F,
   parameter logic [7:0] DEV_CODE = 8'h0B
) (
   input  logic              id_mode_i,
   input  logic              locked_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int CODE_W = (DATA_W < 8) ? DATA_W : 8;

   logic [DATA_W-1:0] mfr_word;
   logic [DATA_W-1:0] dev_word;
   logic [DATA_W-1:0] lock_word;

   always_comb begin
      mfr_word  = '0;
      dev_word  = '0;
      lock_word = '0;
      mfr_word[CODE_W-1:0] = MFR_CODE[CODE_W-1:0];
      dev_word[CODE_W-1:0] = DEV_CODE[CODE_W-1:0];
      lock_word[0]         = locked_i;
   end

   always_comb begin
      rd_data_o = '0;
      if (id_mode_i) begin
         if (rd_addr_i == ADDR_W'(0))      rd_data_o = mfr_word;
         else if (rd_addr_i == ADDR_W'(1)) rd_data_o = dev_word;
         else if (rd_addr_i == ADDR_W'(2)) rd_data_o = lock_word;
      end
   end

   // R8: no identification data leaves the port outside the mode
   always_comb begin
      a_r8_quiet_outside: assert (id_mode_i || rd_data_o == '0);
   end

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
   import nor_cmd_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8,
   parameter int CMP_W  = 15,
   parameter logic [CMP_W-1:0] KEY_ADDR_A = CMP_W'(15'h5555),
   parameter logic [CMP_W-1:0] KEY_ADDR_B = CMP_W'(15'h2AAA)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              locked_i,
   input  logic              wr_in_boot_i,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_req,
   output logic              erase_keep_boot,
   output logic              lock_req,
   output logic              id_enter_req,
   output logic              id_exit_req,
   output logic              id_mode
);

   seq_state_t state, nxt;
   logic at_a, at_b, start_w;
   logic hit_prog, hit_erase, hit_lock, hit_enter, hit_exit;

   assign at_a    = (wr_addr[CMP_W-1:0] == KEY_ADDR_A);
   assign at_b    = (wr_addr[CMP_W-1:0] == KEY_ADDR_B);
   assign start_w = at_a && (wr_data == DATA_W'(KEY_FIRST));

   always_comb begin
      nxt       = state;
      hit_prog  = 1'b0;
      hit_erase = 1'b0;
      hit_lock  = 1'b0;
      hit_enter = 1'b0;
      hit_exit  = 1'b0;
      if (wr_en) begin
         nxt = start_w ? SEQ_KEY1 : SEQ_IDLE;
         unique case (state)
            SEQ_IDLE: begin
               if (!start_w && wr_data == DATA_W'(OP_ID_OFF)) hit_exit = 1'b1;
            end
            SEQ_KEY1: begin
               if (at_b && wr_data == DATA_W'(KEY_SECOND)) nxt = SEQ_KEY2;
            end
            SEQ_KEY2: begin
               if (at_a) begin
                  if (wr_data == DATA_W'(OP_PROGRAM)) nxt = SEQ_PGM;
                  else if (wr_data == DATA_W'(OP_EXTEND)) nxt = SEQ_EXT1;
                  else if (wr_data == DATA_W'(OP_ID_ON)) begin
                     hit_enter = 1'b1;
                     nxt       = SEQ_IDLE;
                  end else if (wr_data == DATA_W'(OP_ID_OFF)) begin
                     hit_exit = 1'b1;
                     nxt      = SEQ_IDLE;
                  end
               end
            end
            SEQ_PGM: begin
               hit_prog = !(locked_i && wr_in_boot_i);
               nxt      = SEQ_IDLE;
            end
            SEQ_EXT1: begin
               if (start_w) nxt = SEQ_EXT2;
            end
            SEQ_EXT2: begin
               if (at_b && wr_data == DATA_W'(KEY_SECOND)) nxt = SEQ_EXT3;
            end
            SEQ_EXT3: begin
               if (at_a && wr_data == DATA_W'(OP_ERASE)) begin
                  hit_erase = 1'b1;
                  nxt       = SEQ_IDLE;
               end else if (at_a && wr_data == DATA_W'(OP_LOCK)) begin
                  hit_lock = 1'b1;
                  nxt      = SEQ_IDLE;
               end
            end
            default: nxt = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state           <= SEQ_IDLE;
         prog_req        <= 1'b0;
         prog_addr       <= '0;
         prog_data       <= '0;
         erase_req       <= 1'b0;
         erase_keep_boot <= 1'b0;
         lock_req        <= 1'b0;
         id_enter_req    <= 1'b0;
         id_exit_req     <= 1'b0;
         id_mode         <= 1'b0;
      end else begin
         state           <= nxt;
         prog_req        <= hit_prog;
         erase_req       <= hit_erase;
         erase_keep_boot <= hit_erase && locked_i;
         lock_req        <= hit_lock && !locked_i;
         id_enter_req    <= hit_enter && !id_mode;
         id_exit_req     <= hit_exit && id_mode;
         if (hit_prog) begin
            prog_addr <= wr_addr;
            prog_data <= wr_data;
         end
         if (hit_enter)     id_mode <= 1'b1;
         else if (hit_exit) id_mode <= 1'b0;
      end
   end

   // R11: one request per cycle at most
   a_r11_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_req, erase_req, lock_req, id_enter_req, id_exit_req}));

   // R11: a request always follows a write cycle
   a_r11_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req || erase_req || lock_req || id_enter_req || id_exit_req) |-> $past(wr_en));

   // R2: a program request only follows the armed state
   a_r2_prog_armed: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> $past(state == SEQ_PGM));

   // R6: identification mode turns on only with its entry pulse
   a_r6_enter_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> id_enter_req);

   // R7: identification mode turns off only with its exit pulse
   a_r7_exit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(id_mode) |-> id_exit_req);

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
   import nor_cmd_pkg::*;
#(
   parameter int         ADDR_W    = 18,
   parameter int         DATA_W    = 8,
   parameter int         CMP_W     = 15,
   parameter int         BOOT_SIZE = 8192,
   parameter bit         BOOT_TOP  = 1'b0,
   parameter logic [7:0] MFR_CODE  = 8'h1F,
   parameter logic [7:0] DEV_CODE  = 8'h0B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_req,
   output logic              erase_keep_boot,
   output logic              lock_req,
   output logic              id_enter_req,
   output logic              id_exit_req,
   output logic              id_mode,
   output logic              boot_locked,
   output logic [DATA_W-1:0] id_rd_data
);

   localparam int BOOT_W = $clog2(BOOT_SIZE);
   localparam int HIGH_W = ADDR_W - BOOT_W;

   if (CMP_W > ADDR_W) begin : g_bad_cmp
      $error("compare width exceeds address width");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("data width must hold a command byte");
   end
   if ((1 << BOOT_W) != BOOT_SIZE || BOOT_W >= ADDR_W) begin : g_bad_boot
      $error("boot region must be a power of two below the array size");
   end

   logic wr_in_boot;
   logic pa_in_boot;

   if (BOOT_TOP) begin : g_boot_high
      assign wr_in_boot = &wr_addr[ADDR_W-1:BOOT_W];
      assign pa_in_boot = &prog_addr[ADDR_W-1:BOOT_W];
   end else begin : g_boot_low
      assign wr_in_boot = (wr_addr[ADDR_W-1:BOOT_W] == HIGH_W'(0));
      assign pa_in_boot = (prog_addr[ADDR_W-1:BOOT_W] == HIGH_W'(0));
   end

   nor_seq_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CMP_W  (CMP_W)
   ) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_en           (wr_en),
      .wr_addr         (wr_addr),
      .wr_data         (wr_data),
      .locked_i        (boot_locked),
      .wr_in_boot_i    (wr_in_boot),
      .prog_req        (prog_req),
      .prog_addr       (prog_addr),
      .prog_data       (prog_data),
      .erase_req       (erase_req),
      .erase_keep_boot (erase_keep_boot),
      .lock_req        (lock_req),
      .id_enter_req    (id_enter_req),
      .id_exit_req     (id_exit_req),
      .id_mode         (id_mode)
   );

   nor_lock_reg u_lock (
      .clk      (clk),
      .por_n    (por_n),
      .set_i    (lock_req),
      .locked_o (boot_locked)
   );

   nor_id_port #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE)
   ) u_id (
      .id_mode_i (id_mode),
      .locked_i  (boot_locked),
      .rd_addr_i (rd_addr),
      .rd_data_o (id_rd_data)
   );

   // R5: no program request lands in a locked boot region
   a_r5_boot_guard: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (prog_req && boot_locked) |-> !pa_in_boot);

   // R3: the erase keep flag reflects the lockout state
   a_r3_keep_boot: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      erase_req |-> (erase_keep_boot == boot_locked));

   // R4: a lockout pulse never repeats once locked
   a_r4_lock_once: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      lock_req |-> !boot_locked);

endmodule

// File: tb/nor_cmd_decoder_test.sv
`timescale 1ns/1ps
module nor_cmd_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [17:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [17:0] rd_addr = '0;
   logic        prog_req, erase_req, erase_keep_boot, lock_req;
   logic        id_enter_req, id_exit_req, id_mode, boot_locked;
   logic [17:0] prog_addr;
   logic [7:0]  prog_data, id_rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   nor_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_req(erase_req), .erase_keep_boot(erase_keep_boot),
      .lock_req(lock_req), .id_enter_req(id_enter_req),
      .id_exit_req(id_exit_req), .id_mode(id_mode),
      .boot_locked(boot_locked), .id_rd_data(id_rd_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [17:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      wr(18'h05555, 8'hAA);
      wr(18'h02AAA, 8'h55);
   endtask

   task automatic six(input logic [7:0] op);
      unlock();
      wr(18'h05555, 8'h80);
      unlock();
      wr(18'h05555, op);
   endtask

   task automatic pulse_rst();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic rd(input logic [17:0] a, input logic [7:0] exp, input string tag);
      rd_addr = a;
      #1;
      chk(tag, {24'h0, id_rd_data}, {24'h0, exp});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 requests", {27'h0, prog_req, erase_req, lock_req, id_enter_req, id_exit_req}, 0);
      chk("R1 flags", {30'h0, id_mode, boot_locked}, 0);
      rst_n = 1'b1; por_n = 1'b1;
      @(negedge clk);

      // R2 program
      unlock(); wr(18'h05555, 8'hA0); wr(18'h03ABC, 8'h5A);
      chk("R2 prog_req", prog_req, 1);
      chk("R2 prog_addr", prog_addr, 18'h03ABC);
      chk("R2 prog_data", prog_data, 8'h5A);
      @(negedge clk);
      chk("R2 single cycle", prog_req, 0);

      // R9 upper address bits ignored
      wr(18'h35555, 8'hAA); wr(18'h12AAA, 8'h55); wr(18'h25555, 8'hA0); wr(18'h00010, 8'h11);
      chk("R9 upper bits ignored", prog_req, 1);
      wr(18'h05554, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00010, 8'h11);
      chk("R9 low bit compared", prog_req, 0);

      // R10 abort and restart
      unlock(); wr(18'h01234, 8'h00); wr(18'h05555, 8'hA0); wr(18'h03000, 8'h22);
      chk("R10 abort", prog_req, 0);
      wr(18'h05555, 8'hAA); wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55);
      wr(18'h05555, 8'hA0); wr(18'h04000, 8'h33);
      chk("R10 restart", prog_req, 1);
      chk("R10 restart data", prog_data, 8'h33);

      // R3 erase unlocked
      six(8'h10);
      chk("R3 erase_req", erase_req, 1);
      chk("R3 keep_boot clear", erase_keep_boot, 0);

      // R6 / R8 / R7 identification mode
      unlock(); wr(18'h05555, 8'h90);
      chk("R6 enter pulse", id_enter_req, 1);
      chk("R6 mode set", id_mode, 1);
      rd(18'h00000, 8'h1F, "R8 mfr code");
      rd(18'h00001, 8'h0B, "R8 dev code");
      rd(18'h00002, 8'h00, "R8 lock status clear");
      rd(18'h00003, 8'h00, "R8 other addr");
      rd(18'h20000, 8'h00, "R8 high addr");
      unlock(); wr(18'h05555, 8'h90);
      chk("R6 no pulse when on", id_enter_req, 0);
      wr(18'h01234, 8'hF0);
      chk("R7 short exit pulse", id_exit_req, 1);
      chk("R7 short exit mode", id_mode, 0);
      rd(18'h00000, 8'h00, "R8 quiet outside mode");
      wr(18'h01234, 8'hF0);
      chk("R7 no pulse when off", id_exit_req, 0);
      unlock(); wr(18'h05555, 8'h90);
      unlock(); wr(18'h05555, 8'hF0);
      chk("R7 long exit pulse", id_exit_req, 1);
      chk("R7 long exit mode", id_mode, 0);
      unlock(); wr(18'h05555, 8'h90);
      pulse_rst();
      chk("R12 reset clears mode", id_mode, 0);

      // R4 lockout
      six(8'h40);
      chk("R4 lock pulse", lock_req, 1);
      @(negedge clk);
      chk("R4 locked", boot_locked, 1);
      unlock(); wr(18'h05555, 8'h90);
      rd(18'h00002, 8'h01, "R8 lock status set");
      wr(18'h00000, 8'hF0);
      six(8'h40);
      chk("R4 no second pulse", lock_req, 0);

      // R5 boot region guard
      unlock(); wr(18'h05555, 8'hA0); wr(18'h01FFF, 8'h00);
      chk("R5 top of boot refused", prog_req, 0);
      unlock(); wr(18'h05555, 8'hA0); wr(18'h00000, 8'h00);
      chk("R5 base of boot refused", prog_req, 0);
      unlock(); wr(18'h05555, 8'hA0); wr(18'h02000, 8'h44);
      chk("R5 above boot issued", prog_req, 1);

      // R3 erase while locked
      six(8'h10);
      chk("R3 erase locked", erase_req, 1);
      chk("R3 keep_boot set", erase_keep_boot, 1);

      // R12 / R4 reset interplay
      pulse_rst();
      chk("R12 lock kept over reset", boot_locked, 1);
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      chk("R4 por clears lock", boot_locked, 0);
      unlock(); wr(18'h05555, 8'hA0); wr(18'h00005, 8'h66);
      chk("R5 boot open after por", prog_req, 1);

      // Sweep of every third-cycle byte (R2, R6, R10)
      for (int d = 0; d < 256; d++) begin
         pulse_rst();
         unlock(); wr(18'h05555, 8'(d));
         chk("R6 sweep enter", id_enter_req, (d == 8'h90) ? 1 : 0);
         chk("R6 sweep mode", id_mode, (d == 8'h90) ? 1 : 0);
         wr(18'h03000, 8'h77);
         chk("R10 sweep prog", prog_req, (d == 8'hA0) ? 1 : 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule